// File: doc/BRIEF.md
# Synchronisable fractional clock-enable divider bank

This block holds four independent clock-enable generators, one per execution engine. Each generator runs freely at the system clock. It is programmed with a divisor that has a 16-bit whole part and an 8-bit fraction. It emits single-cycle `tick` pulses whose average rate is the system clock divided by that divisor. An engine advances only on cycles where its enable is high, so it runs at a controlled rate below the system clock.

The phase of each generator is held in 1/256 units. A restart mask zeroes the phase of any set of channels on one shared cycle, so channels with equal divisors then pulse in exact lockstep. A run register gates each divider's pulses onto the engine enable outputs. Clearing a run bit does not stop the divider, so a re-enabled engine is still in step with its peers. A start mask sets run bits and restarts the matching dividers on the same cycle.

Top module: `clken_bank`

## Requirements
- R1: After a synchronous active-low reset, every divisor is 1.0, every phase is zero and the run register is clear: `tick` reads 4'b1111, `eng_en` and `run` read 0.
- R2: With a whole divisor n (fraction 0, n >= 1), a channel pulses `tick` for exactly one cycle every n cycles. After a restart, the first pulse falls in the n-th cycle, where the cycle right after the restarting edge is the first.
- R3: A divisor of 1.0, or a whole part of 0 with a nonzero fraction, pulses `tick` on every cycle.
- R4: Fractional divisors: each cycle the phase grows by 256. If the result reaches int*256+frac, the channel pulses and keeps the excess as its new phase. If that excess is 256 or more (possible only after a divisor shrink), the phase becomes 0. For example, 1.5 (int 1, frac 128) gives 2 pulses in every 3 cycles.
- R5: A whole part of 0 with fraction 0 counts as 65536.0, so pulses are 65536 cycles apart.
- R6: `restart_mask` bit i zeroes channel i's phase at the clock edge, on the same edge for every selected channel. Unselected channels are not affected.
- R7: `div_we` writes `div_int`/`div_frac` into the channel chosen by `div_sel` (0..3). The new divisor governs the update at the next edge, and the phase is not cleared.
- R8: `run_we` loads `run` from `run_val`. `eng_en[i]` equals `tick[i] & run[i]`, and the dividers keep running regardless of `run`.
- R9: `start_mask` bit i sets `run[i]` (ORed after any `run_we` load on the same edge) and zeroes channel i's phase on that edge. Channels started together with equal divisors give identical `tick` from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_we | input | 1 | Divisor write strobe |
| div_sel | input | 2 | Channel selected by a divisor write |
| div_int | input | 16 | Whole part of the divisor |
| div_frac | input | 8 | Fractional part of the divisor, in 1/256 |
| restart_mask | input | 4 | Per-channel phase restart |
| run_we | input | 1 | Run register load strobe |
| run_val | input | 4 | Value loaded into the run register |
| start_mask | input | 4 | Set run bits and restart phase together |
| tick | output | 4 | Free-running divider pulses |
| eng_en | output | 4 | Engine enables: tick gated by run |
| run | output | 4 | Run register |

## Verification
A wrong phase value shows up on `tick` as a pulse that is early, late, missing or doubled. With small divisors this appears within a few cycles. With the 65536 divisor it may not appear until the end of a full interval. The bench therefore keeps its own phase for every channel and compares all three outputs on every cycle, so any divergence is reported in the cycle it first becomes visible. Lockstep, the ignored run state and the phase left untouched by divisor writes are covered by directed sequences that compare pulses between channels.

// File: rtl/clken_pkg.sv
// Package: shared sizing constants for the clock-enable divider bank.
// Assumes: divisors are fixed point with FRAC_W fractional bits.
package clken_pkg;
    localparam int CK_NCH    = 4;
    localparam int CK_INT_W  = 16;
    localparam int CK_FRAC_W = 8;
endpackage

// File: rtl/clken_chan.sv
// Module: one fractional clock-enable generator.
// Holds its own divisor and a phase in 1/2**FRAC_W units. Each cycle it adds
// one unit cycle to the phase and pulses when the phase reaches the divisor.
// Assumes: clr and div_we are single-cycle strobes, sampled at the edge.
module clken_chan #(
    parameter int INT_W  = clken_pkg::CK_INT_W,
    parameter int FRAC_W = clken_pkg::CK_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              clr,
    output logic              tick
);
    localparam int PH_W = INT_W + FRAC_W + 1;
    localparam logic [PH_W-1:0] ONE  = PH_W'(1) << FRAC_W;
    localparam logic [PH_W-1:0] FULL = PH_W'(1) << (INT_W + FRAC_W);

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic [PH_W-1:0]   phase_q;
    logic [PH_W-1:0]   dfix;
    logic [PH_W-1:0]   sum;
    logic [PH_W-1:0]   rem;

    // Effective divisor: whole 0 means the maximum, below 1.0 clamps to 1.0.
    always_comb begin
        if (int_q == '0 && frac_q == '0)
            dfix = FULL;
        else if (int_q == '0)
            dfix = ONE;
        else
            dfix = {1'b0, int_q, frac_q};
    end

    // Candidate phase, pulse decision and excess.
    always_comb begin
        sum  = phase_q + ONE;
        tick = (sum >= dfix);
        rem  = sum - dfix;
    end

    // Divisor register: a write takes effect from the next update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= INT_W'(1);
            frac_q <= '0;
        end else if (div_we) begin
            int_q  <= div_int;
            frac_q <= div_frac;
        end
    end

    // Phase accumulator: restart wins, otherwise advance and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (clr)
            phase_q <= '0;
        else if (tick)
            phase_q <= (rem >= ONE) ? '0 : rem;
        else
            phase_q <= sum;
    end

    // R6: a restart leaves a zero phase.
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase_q == '0));

    // R2: with a divisor of 2.0 or more, a pulse is never followed by another.
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !div_we && dfix >= (ONE << 1)) |=> !tick);

    // R4: a normal wrap keeps the excess below one cycle.
    a_r4_excess_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (phase_q < ONE));
endmodule

// File: rtl/clken_run_ctl.sv
// Module: run register of the engines.
// Loads from run_val on run_we, then ORs in start_mask on the same edge.
// Assumes: the strobes are sampled only at the clock edge.
module clken_run_ctl #(
    parameter int NCH = clken_pkg::CK_NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_we,
    input  logic [NCH-1:0] run_val,
    input  logic [NCH-1:0] start_mask,
    output logic [NCH-1:0] run
);
    logic [NCH-1:0] base;

    // Value before the start bits are merged in.
    always_comb base = run_we ? run_val : run;

    // Run register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= '0;
        else
            run <= base | start_mask;
    end

    // R9: started channels are running after the edge.
    a_r9_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (start_mask != '0) |=> ((run & $past(start_mask)) == $past(start_mask)));

    // R8: a plain load takes the written value.
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        (run_we && start_mask == '0) |=> (run == $past(run_val)));
endmodule

// File: rtl/clken_bank.sv
// Module: bank of NCH fractional clock-enable generators with a run register.
// Dividers run freely. Engine enables are the pulses gated by the run bits.
// Assumes: div_sel addresses an existing channel.
module clken_bank #(
    parameter int NCH    = clken_pkg::CK_NCH,
    parameter int INT_W  = clken_pkg::CK_INT_W,
    parameter int FRAC_W = clken_pkg::CK_FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   div_we,
    input  logic [$clog2(NCH)-1:0] div_sel,
    input  logic [INT_W-1:0]       div_int,
    input  logic [FRAC_W-1:0]      div_frac,
    input  logic [NCH-1:0]         restart_mask,
    input  logic                   run_we,
    input  logic [NCH-1:0]         run_val,
    input  logic [NCH-1:0]         start_mask,
    output logic [NCH-1:0]         tick,
    output logic [NCH-1:0]         eng_en,
    output logic [NCH-1:0]         run
);
    localparam int SEL_W = $clog2(NCH);

    logic [NCH-1:0] clr;

    // Restart comes from either the plain or the combined command.
    always_comb clr = restart_mask | start_mask;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        clken_chan #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_we   (div_we && (div_sel == SEL_W'(g))),
            .div_int  (div_int),
            .div_frac (div_frac),
            .clr      (clr[g]),
            .tick     (tick[g])
        );
    end

    clken_run_ctl #(.NCH(NCH)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_we     (run_we),
        .run_val    (run_val),
        .start_mask (start_mask),
        .run        (run)
    );

    // Engine enables.
    always_comb eng_en = tick & run;

    // R8: an engine never sees an enable without a divider pulse.
    a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_en & ~tick) == '0);
endmodule

// File: tb/sim_clken_bank.sv
module sim_clken_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_we = 1'b0;
    logic [1:0] div_sel = '0;
    logic [15:0] div_int = '0;
    logic [7:0] div_frac = '0;
    logic [3:0] restart_mask = '0;
    logic       run_we = 1'b0;
    logic [3:0] run_val = '0;
    logic [3:0] start_mask = '0;
    logic [3:0] tick, eng_en, run;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    longint ph[NCH];
    longint df[NCH];
    logic [3:0] m_run;
    int tick_cnt[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    clken_bank u0 (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_sel(div_sel),
        .div_int(div_int), .div_frac(div_frac), .restart_mask(restart_mask),
        .run_we(run_we), .run_val(run_val), .start_mask(start_mask),
        .tick(tick), .eng_en(eng_en), .run(run)
    );

    function automatic longint eff(input int i, input int f);
        if (i == 0 && f == 0) return 64'd65536 * 256;
        if (i == 0) return 256;
        return longint'(i) * 256 + f;
    endfunction

    function automatic logic [3:0] exp_tick();
        logic [3:0] t;
        for (int c = 0; c < NCH; c++) t[c] = (ph[c] + 256 >= df[c]);
        return t;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin ph[c] = 0; df[c] = 256; tick_cnt[c] = 0; end
        m_run = '0;
    endtask

    // One cycle: at negedge compare outputs with the model, then drive
    // the given inputs and advance the model past the next edge.
    task automatic step(input logic we, input int sel, input int di, input int dfr,
                        input logic [3:0] rm, input logic rwe, input logic [3:0] rv,
                        input logic [3:0] sm);
        logic [3:0] et;
        longint nx;
        @(negedge clk);
        et = exp_tick();
        check(cur_req, tick, et, "tick");
        check(cur_req, eng_en, et & m_run, "eng_en");
        check(cur_req, run, m_run, "run");
        for (int c = 0; c < NCH; c++) if (tick[c]) tick_cnt[c]++;
        div_we = we; div_sel = 2'(sel); div_int = 16'(di); div_frac = 8'(dfr);
        restart_mask = rm; run_we = rwe; run_val = rv; start_mask = sm;
        for (int c = 0; c < NCH; c++) begin
            nx = ph[c] + 256;
            if (rm[c] || sm[c]) ph[c] = 0;
            else if (nx >= df[c]) ph[c] = (nx - df[c] >= 256) ? 0 : nx - df[c];
            else ph[c] = nx;
        end
        if (we) df[sel] = eff(di, dfr);
        m_run = (rwe ? rv : m_run) | sm;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 4'b0, 0, 4'b0, 4'b0);
    endtask

    task automatic wdiv(input int sel, input int di, input int dfr);
        step(1, sel, di, dfr, 4'b0, 0, 4'b0, 4'b0);
    endtask

    task automatic clr_cnt();
        for (int c = 0; c < NCH; c++) tick_cnt[c] = 0;
    endtask

    task automatic count_check(input string req, input int ch, input int expv);
        checks++;
        if (tick_cnt[ch] != expv) begin
            errors++;
            $display("FAIL %s pulse count ch%0d actual=%0d expected=%0d", req, ch, tick_cnt[ch], expv);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        check("R1", tick, 4'b1111, "reset tick");
        check("R1", eng_en, 4'b0000, "reset eng_en");
        check("R1", run, 4'b0000, "reset run");
        idle(2);

        // R2: whole divisors 3 on ch0, 5 on ch1, restart both
        cur_req = "R2";
        wdiv(0, 3, 0);
        wdiv(1, 5, 0);
        step(0, 0, 0, 0, 4'b0011, 0, 4'b0, 4'b0);
        clr_cnt();
        idle(30);
        count_check("R2", 0, 10);
        count_check("R2", 1, 6);

        // R3: 1.0 and sub-1.0 on ch2
        cur_req = "R3";
        wdiv(2, 0, 77);
        clr_cnt();
        idle(12);
        count_check("R3", 2, 12);

        // R4: 1.5 on ch3 and 2.25 on ch2
        cur_req = "R4";
        wdiv(3, 1, 128);
        wdiv(2, 2, 64);
        step(0, 0, 0, 0, 4'b1100, 0, 4'b0, 4'b0);
        clr_cnt();
        idle(36);
        count_check("R4", 3, 24);
        count_check("R4", 2, 16);
        // shrink with large leftover: ch1 at 5 -> 1.25 mid phase
        wdiv(1, 200, 0);
        idle(150);
        wdiv(1, 1, 64);
        idle(20);

        // R7: divisor write does not reset phase (model keeps phase)
        cur_req = "R7";
        wdiv(0, 4, 0);
        idle(9);
        wdiv(0, 7, 3);
        idle(25);

        // R6: restart only ch1, ch0 unaffected
        cur_req = "R6";
        wdiv(0, 6, 0);
        wdiv(1, 6, 0);
        idle(3);
        step(0, 0, 0, 0, 4'b0010, 0, 4'b0, 4'b0);
        idle(20);

        // R8: run load, gating, divider free-running while not running
        cur_req = "R8";
        step(0, 0, 0, 0, 4'b0, 1, 4'b1010, 4'b0);
        idle(15);
        step(0, 0, 0, 0, 4'b0, 1, 4'b0000, 4'b0);
        clr_cnt();
        idle(24);
        count_check("R8", 1, 4);

        // R9: start ch0 and ch1 (equal divisors 2.75) in lockstep
        cur_req = "R9";
        wdiv(0, 2, 192);
        wdiv(1, 2, 192);
        idle(4);
        step(0, 0, 0, 0, 4'b0, 1, 4'b0100, 4'b0011);
        for (int k = 0; k < 30; k++) begin
            step(0, 0, 0, 0, 4'b0, 0, 4'b0, 4'b0);
            checks++;
            if (tick[0] !== tick[1]) begin
                errors++;
                $display("FAIL R9 lockstep actual=%b expected=%b", tick[1], tick[0]);
            end
        end
        // disable ch1 and re-enable: still in lockstep with ch0
        step(0, 0, 0, 0, 4'b0, 1, 4'b0101, 4'b0);
        idle(7);
        step(0, 0, 0, 0, 4'b0, 1, 4'b0111, 4'b0);
        for (int k = 0; k < 20; k++) begin
            step(0, 0, 0, 0, 4'b0, 0, 4'b0, 4'b0);
            checks++;
            if (eng_en[0] !== eng_en[1]) begin
                errors++;
                $display("FAIL R9 re-enable sync actual=%b expected=%b", eng_en[1], eng_en[0]);
            end
        end

        // R5: whole 0, fraction 0 -> 65536 cycles between pulses
        cur_req = "R5";
        wdiv(2, 0, 0);
        step(0, 0, 0, 0, 4'b0100, 0, 4'b0, 4'b0);
        clr_cnt();
        idle(65536 + 10);
        count_check("R5", 2, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule